// File: doc/BRIEF.md
# Warp Issue Scheduler with Eligibility Tracking

This block sits in front of the execution lanes of one compute unit and decides, every clock cycle, which of up to `NUM_WARPS` resident warps issues its next instruction. Each warp reports two flags: whether it is resident (active) and whether every operand of its current instruction is ready. The execution side reports how many lanes are free. A warp may issue only when a full set of `LANES_PER_WARP` lanes (32 by default) is free and its operands are ready.

Among the warps that may issue, one is picked by a rotating search. The search starts at the warp after the one that issued last, so no ready warp waits forever. The pick is combinational from the current inputs, so a different warp can issue on every consecutive cycle with no gap. Each warp's program counter is held in its own register inside the block. The picked warp's program counter is shown on `issue_pc` and then steps by one at the clock edge.

Every warp is also reported each cycle as idle, blocked, ready-but-waiting or issuing. This gives the surrounding pipeline and any debug view a live picture of the warp pool.

Top module: `wsched_top`

## Requirements
- R1: After reset every program counter is 0 and the rotating search starts at warp 0, so the first pick is the lowest-indexed warp that may issue.
- R2: A warp may issue only when it is active, its ready flag is high and `lanes_free` is at least `LANES_PER_WARP`. With 31 free lanes nothing issues; with 32 or more lanes, ready warps may issue.
- R3: `warp_state[2*i+1:2*i]` encodes warp i as follows: 2'b00 when inactive, 2'b01 when active but not able to issue, 2'b10 when able to issue but not picked, and 2'b11 when picked this cycle. An inactive warp always reads 2'b00.
- R4: `issue_valid` is high exactly when at least one warp may issue. When it is high, exactly one warp reads 2'b11 and `issue_warp` holds its index.
- R5: The picked warp is the first one able to issue when searching upward from the warp after the last picked warp and wrapping from `NUM_WARPS-1` back to 0.
- R6: In a cycle where no warp may issue, `issue_valid` is low. No program counter changes, and the search start stays where it was.
- R7: While `issue_valid` is high, `issue_pc` equals the picked warp's program counter. That counter is one higher on the next cycle, and the other counters are unchanged.
- R8: Issues on consecutive cycles need no idle cycle. With all warps able to issue, the picks run 0, 1, 2, … on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_active | input | NUM_WARPS | Per-warp resident flag |
| warp_ready | input | NUM_WARPS | Per-warp operands-ready flag |
| lanes_free | input | LANE_W | Count of free execution lanes |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the issuing warp |
| issue_pc | output | PC_W | Program counter of the issuing warp |
| warp_state | output | 2*NUM_WARPS | Per-warp 2-bit state, warp i at bits 2i+1:2i |

## Verification
The hardest cases to reach are those where the rotating search must wrap past the top warp, and where an idle cycle has to leave the search start untouched so that the next pick still continues from the right place. The stimulus table sets these up on purpose. It alternates sparse ready patterns, so the pick jumps from warp 2 back to warp 0 and from warp 7 to warp 0. It then inserts cycles with nothing able to issue, either because operands are blocked or because only 31 lanes are free. Finally it resumes with patterns whose correct pick depends on the stored start. A reference model in the bench tracks every program counter, so a counter that moves on an idle cycle is caught at that warp's next issue.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'b00,
        WS_BLOCK = 2'b01,
        WS_WAIT  = 2'b10,
        WS_ISSUE = 2'b11
    } wstate_e;

    typedef struct packed {
        logic can_issue;
        logic resident;
    } wflags_t;

    function automatic wstate_e classify(input wflags_t f, input logic picked);
        if (!f.resident)       return WS_IDLE;
        else if (!f.can_issue) return WS_BLOCK;
        else if (picked)       return WS_ISSUE;
        else                   return WS_WAIT;
    endfunction

endpackage

// File: rtl/wsched_elig.sv
module wsched_elig #(
    parameter int NUM_WARPS      = 8,
    parameter int LANE_W         = 7,
    parameter int LANES_PER_WARP = 32
) (
    input  logic [NUM_WARPS-1:0] warp_active,
    input  logic [NUM_WARPS-1:0] warp_ready,
    input  logic [LANE_W-1:0]    lanes_free,
    output wsched_pkg::wflags_t  flags [NUM_WARPS],
    output logic [NUM_WARPS-1:0] can_issue
);
    localparam logic [LANE_W-1:0] NEED = LANE_W'(LANES_PER_WARP);

    logic lanes_ok;
    assign lanes_ok = (lanes_free >= NEED);

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_warp
        assign can_issue[i]       = warp_active[i] & warp_ready[i] & lanes_ok;
        assign flags[i].resident  = warp_active[i];
        assign flags[i].can_issue = can_issue[i];
    end
endmodule

// File: rtl/wsched_rr_arb.sv
module wsched_rr_arb #(
    parameter int NUM_WARPS = 8,
    localparam int IDX_W    = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] req,
    output logic                 gnt_vld,
    output logic [IDX_W-1:0]     gnt_idx,
    output logic [NUM_WARPS-1:0] gnt_mask
);
    logic [IDX_W-1:0] last_q;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            int cand;
            cand = (int'(last_q) + k) % NUM_WARPS;
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end

    always_comb begin
        gnt_mask = '0;
        if (gnt_vld) gnt_mask[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= IDX_W'(NUM_WARPS - 1);
        else if (gnt_vld) last_q <= gnt_idx;
    end

    // R4: the grant points at one requester only
    a_r4_grant_is_req: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req[gnt_idx]);
    // R4: at most one grant bit
    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_mask));
    // R6: search start holds on idle cycles
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !gnt_vld |=> $stable(last_q));
    // R5: any request leads to a grant
    a_r5_no_starve: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> gnt_vld);
endmodule

// File: rtl/wsched_pc_file.sv
module wsched_pc_file #(
    parameter int NUM_WARPS = 8,
    parameter int PC_W      = 16,
    localparam int IDX_W    = $clog2(NUM_WARPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx,
    output logic [PC_W-1:0]  rd_pc
);
    logic [PC_W-1:0] pc_q [NUM_WARPS];
    logic [NUM_WARPS*PC_W-1:0] pc_flat;

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_pc
        always_ff @(posedge clk) begin
            if (rst)                               pc_q[i] <= '0;
            else if (adv && adv_idx == IDX_W'(i)) pc_q[i] <= pc_q[i] + 1'b1;
        end
        assign pc_flat[i*PC_W +: PC_W] = pc_q[i];
    end

    assign rd_pc = pc_q[adv_idx];

    // R6: no counter moves without an issue
    a_r6_pc_stable: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pc_flat));
    // R7: the issuing warp's counter steps by one
    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> pc_q[$past(adv_idx)] == $past(rd_pc) + 1'b1);
endmodule

// File: rtl/wsched_top.sv
module wsched_top #(
    parameter int NUM_WARPS      = 8,
    parameter int LANE_W         = 7,
    parameter int LANES_PER_WARP = 32,
    parameter int PC_W           = 16,
    localparam int IDX_W         = $clog2(NUM_WARPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_WARPS-1:0]   warp_active,
    input  logic [NUM_WARPS-1:0]   warp_ready,
    input  logic [LANE_W-1:0]      lanes_free,
    output logic                   issue_valid,
    output logic [IDX_W-1:0]       issue_warp,
    output logic [PC_W-1:0]        issue_pc,
    output logic [2*NUM_WARPS-1:0] warp_state
);
    import wsched_pkg::*;

    wflags_t              flags [NUM_WARPS];
    logic [NUM_WARPS-1:0] can_issue;
    logic [NUM_WARPS-1:0] gnt_mask;

    wsched_elig #(
        .NUM_WARPS(NUM_WARPS), .LANE_W(LANE_W), .LANES_PER_WARP(LANES_PER_WARP)
    ) elig_i (
        .warp_active(warp_active), .warp_ready(warp_ready),
        .lanes_free(lanes_free), .flags(flags), .can_issue(can_issue)
    );

    wsched_rr_arb #(.NUM_WARPS(NUM_WARPS)) arb_i (
        .clk(clk), .rst(rst), .req(can_issue),
        .gnt_vld(issue_valid), .gnt_idx(issue_warp), .gnt_mask(gnt_mask)
    );

    wsched_pc_file #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) pcs_i (
        .clk(clk), .rst(rst), .adv(issue_valid),
        .adv_idx(issue_warp), .rd_pc(issue_pc)
    );

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_state
        wstate_e st;
        assign st = classify(flags[i], gnt_mask[i]);
        assign warp_state[2*i +: 2] = st;

        // R3: an inactive warp is always reported idle
        a_r3_inactive_idle: assert property (@(posedge clk) disable iff (rst)
            !warp_active[i] |-> warp_state[2*i +: 2] == 2'b00);
    end

    // R2: short on lanes means nothing issues
    a_r2_lanes_gate: assert property (@(posedge clk) disable iff (rst)
        lanes_free < LANE_W'(LANES_PER_WARP) |-> !issue_valid);
endmodule

// File: tb/wsched_top_tb_top.sv
module wsched_top_tb_top;
    localparam int N   = 8;
    localparam int LW  = 7;
    localparam int PW  = 16;
    localparam int NV  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  act = '0;
    logic [N-1:0]  rdy = '0;
    logic [LW-1:0] lanes = '0;
    logic          issue_valid;
    logic [2:0]    issue_warp;
    logic [PW-1:0] issue_pc;
    logic [2*N-1:0] warp_state;

    always #2 clk = ~clk;

    wsched_top #(.NUM_WARPS(N), .LANE_W(LW), .LANES_PER_WARP(32), .PC_W(PW)) dut_i (
        .clk(clk), .rst(rst), .warp_active(act), .warp_ready(rdy),
        .lanes_free(lanes), .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_pc(issue_pc), .warp_state(warp_state)
    );

    localparam logic [7:0] V_ACT [NV] = '{8'hFF,8'hFF,8'hFF,8'hFF,8'h0F,8'hFF,
                                          8'hFF,8'h81,8'h81,8'h7F,8'h02,8'h02};
    localparam logic [7:0] V_RDY [NV] = '{8'hFF,8'hFF,8'h05,8'h05,8'hF0,8'hFF,
                                          8'h80,8'h81,8'h81,8'hFF,8'h02,8'h02};
    localparam logic [6:0] V_LAN [NV] = '{7'd32,7'd32,7'd64,7'd64,7'd32,7'd31,
                                          7'd127,7'd32,7'd32,7'd40,7'd32,7'd32};
    localparam logic       V_VLD [NV] = '{1,1,1,1,0,0,1,1,1,1,1,1};
    localparam int         V_IDX [NV] = '{0,1,2,0,0,0,7,0,7,0,1,1};

    int n_chk = 0;
    int n_bad = 0;
    int mpc [N];
    int mlast;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) mpc[i] = 0;
        mlast = N - 1;
    endtask

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] r, input logic [LW-1:0] l);
        @(negedge clk);
        act = a; rdy = r; lanes = l;
        #1;
    endtask

    // compare outputs with the model; then advance the model as the clock edge will
    task automatic step(input string req, input bit use_tab, input bit tv, input int ti);
        bit ok_lane;
        bit mv;
        int ms;
        ok_lane = (lanes >= 32);
        mv = 0; ms = 0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (mlast + k) % N;
            if (!mv && act[c] && rdy[c] && ok_lane) begin mv = 1; ms = c; end
        end
        if (use_tab) begin
            chk(mv == tv, {req, " table valid"}, int'(mv), int'(tv));
            if (tv) chk(ms == ti, {req, " table index"}, ms, ti);
        end
        chk(issue_valid == mv, {req, " R4 valid"}, int'(issue_valid), int'(mv));
        if (mv) begin
            chk(int'(issue_warp) == ms, {req, " R5 index"}, int'(issue_warp), ms);
            chk(int'(issue_pc) == mpc[ms], {req, " R7 pc"}, int'(issue_pc), mpc[ms]);
        end
        for (int i = 0; i < N; i++) begin
            int es;
            if (!act[i])                      es = 0;
            else if (!(rdy[i] && ok_lane))    es = 1;
            else if (mv && ms == i)           es = 3;
            else                              es = 2;
            chk(int'(warp_state[2*i +: 2]) == es, {req, " R3 state"},
                int'(warp_state[2*i +: 2]), es);
        end
        if (mv) begin
            mpc[ms] = (mpc[ms] + 1) % (1 << PW);
            mlast = ms;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 / R3: reset state with no warp resident
        step("R1 reset", 0, 0, 0);

        // table walk: R2, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            drive(V_ACT[v], V_RDY[v], V_LAN[v]);
            step("R5 R6 R2 table", 1, V_VLD[v], V_IDX[v]);
        end

        // R2 lane boundary: 31 blocks, 32 allows
        drive(8'h10, 8'h10, 7'd31);
        step("R2 lanes31", 1, 0, 0);
        drive(8'h10, 8'h10, 7'd32);
        step("R2 lanes32", 1, 1, 4);

        // R6: idle cycles keep counters and search start; next pick resumes at warp 5
        drive(8'hFF, 8'h00, 7'd64);
        step("R6 idle", 1, 0, 0);
        drive(8'hFF, 8'h00, 7'd64);
        step("R6 idle2", 1, 0, 0);
        drive(8'hFF, 8'hFF, 7'd64);
        step("R6 resume", 1, 1, 5);

        // R8: back-to-back issues with no gap
        for (int k = 0; k < 2 * N; k++) begin
            drive(8'hFF, 8'hFF, 7'd100);
            step("R8 back to back", 1, 1, (6 + k) % N);
        end

        // R1: mid-run reset clears counters and search start
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        act = 8'hFF; rdy = 8'hFF; lanes = 7'd32;
        #1;
        step("R1 after reset", 1, 1, 0);
        chk(issue_pc == '0, "R1 pc zero", int'(issue_pc), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule